// File: doc/BRIEF.md
# Translation Unit Control and Status Registers

This block is the register front end of an address-translation unit. Software reaches it through a simple 32-bit read/write port. It holds the global controls for the unit: translation enable, bypass of all traffic, statistics enable and the per-fault reaction enables. The decoded enables go out as plain level outputs to the translation datapath.

The block also latches fault events from the datapath into sticky flags that software clears by writing ones. It combines the flags with their interrupt enables to drive one interrupt line. Hit, miss and stall events are counted in saturating counters.

Two invalidation commands are sequenced here. A whole-TLB clear and a targeted shoot-down of one line of four consecutive 4 KB pages are each presented to the TLB as a request that is held until the matching done input. While a command runs, a readable busy bit is set.

Top module: `xlat_ctrl_csr`

## Requirements
- R1: After synchronous reset every register reads 0, and the outputs `irq`, `xlat_en`, `bypass_all`, `stats_en`, `tlb_clr_req` and `sd_req` are 0.
- R2: The control word at offset 0x00 stores bits 0 (translation enable, drives `xlat_en`), 1 (statistics enable, `stats_en`), 8 (bypass, `bypass_all`), 9/10/11 (write-violation exception/interrupt/abort enable), 17 (invalid-entry detect), 18/19 (invalid-entry exception/abort enable) and 24/25/26 (cap exception/interrupt/abort enable). `abort_en` and `exc_en` carry index 2 = cap, 1 = invalid entry, 0 = write violation. The command bits 2 and 3 always read 0. `reg_rdata` holds the word addressed in the previous cycle.
- R3: A fault pulse sets its sticky flag: cap exceeded at bit 27, invalid entry at bit 20 and write violation at bit 12 of offset 0x00. The invalid-entry flag is set only while bit 17 is 1.
- R4: Writing 1 to a flag bit at offset 0x00 clears that flag, and writing 0 leaves it. A fault arriving in the same cycle as its clear leaves the flag set.
- R5: `irq` is 1 exactly when the cap flag is set with bit 25 set, or the write-violation flag is set with bit 10 set. The invalid-entry flag never raises `irq`.
- R6: The hit, miss and stall counters read at offsets 0x08, 0x0C and 0x10. Each adds one per cycle in which its event input is high while statistics are enabled, and holds its value otherwise.
- R7: A write to offset 0x00 with bit 3 set zeroes all three counters on the clock edge after the write.
- R8: A counter at all-ones stays at all-ones on further events.
- R9: Writing bit 2 of offset 0x00 raises `tlb_clr_req` and busy bit 7 on the next cycle. Both stay 1 until `tlb_clr_done` is seen, and drop in the cycle after it.
- R10: A write to offset 0x18 with bit 30 set starts a shoot-down. `sd_page` takes the low PN_W bits of the written data with bits 1:0 forced to 0, and `sd_req` and readable bit 31 stay 1 until `sd_done` is seen. Offset 0x18 reads the busy flag at bit 31 and the page at bits PN_W-1:0.
- R11: A clear or shoot-down command written while either operation is busy is ignored: no request is raised, and the stored page is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ev_hit | input | 1 | TLB hit event |
| ev_miss | input | 1 | TLB miss event |
| ev_stall | input | 1 | Stall event |
| flt_cap | input | 1 | Address-cap exceeded fault |
| flt_pte | input | 1 | Invalid page-table entry fault |
| flt_wrv | input | 1 | Write violation fault |
| xlat_en | output | 1 | Translation enable |
| bypass_all | output | 1 | Pass all addresses untranslated |
| stats_en | output | 1 | Statistics enable |
| abort_en | output | 3 | Per-fault abort enables |
| exc_en | output | 3 | Per-fault exception enables |
| irq | output | 1 | Fault interrupt |
| tlb_clr_req | output | 1 | Whole-TLB clear request |
| tlb_clr_done | input | 1 | Clear finished |
| sd_req | output | 1 | Shoot-down request |
| sd_page | output | PN_W | Base page number of the four-page line |
| sd_done | input | 1 | Shoot-down finished |

## Verification
A flag that is lost or stuck shows up on the next read of offset 0x00, and on `irq` one cycle after the fault or the clearing write. A busy state that does not match the request is exposed at once on `tlb_clr_req` or `sd_req`, and by a command that is wrongly accepted or refused. A counter that misses an increment, wraps or clears late gives a wrong value on the readback one cycle after the address is presented. The bench therefore reads back after each stimulus, and it times each sample after the register edge that should change the value.

// File: rtl/xlat_csr_pkg.sv
package xlat_csr_pkg;
  localparam int OFF_CTL   = 'h00;
  localparam int OFF_HIT   = 'h08;
  localparam int OFF_MISS  = 'h0C;
  localparam int OFF_STALL = 'h10;
  localparam int OFF_SD    = 'h18;

  // fault index order used on every fault vector
  localparam int F_WRV = 0;
  localparam int F_PTE = 1;
  localparam int F_CAP = 2;
  localparam int NFLT  = 3;
  localparam int NCNT  = 3;

  localparam int B_ENABLE  = 0;
  localparam int B_STATS   = 1;
  localparam int B_CLR     = 2;
  localparam int B_SCLR    = 3;
  localparam int B_BUSY    = 7;
  localparam int B_BYPASS  = 8;
  localparam int B_PTE_DET = 17;
  localparam int B_SD_GO   = 30;
  localparam int B_SD_BUSY = 31;

  localparam logic [31:0] CTL_RW_MASK = 32'h070E_0F03;

  typedef logic [4:0] bitpos_t;
  localparam bitpos_t FLAG_POS [NFLT] = '{5'd12, 5'd20, 5'd27};
  localparam bitpos_t ABT_POS  [NFLT] = '{5'd11, 5'd19, 5'd26};
  localparam bitpos_t EXC_POS  [NFLT] = '{5'd9,  5'd18, 5'd24};
endpackage

// File: rtl/xlat_csr_fault.sv
module xlat_csr_fault
  import xlat_csr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NFLT-1:0] flt_in,
  input  logic [NFLT-1:0] det_en,
  input  logic [NFLT-1:0] w1c,
  input  logic [NFLT-1:0] int_en,
  output logic [NFLT-1:0] flags,
  output logic            irq
);
  for (genvar i = 0; i < NFLT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                      flags[i] <= 1'b0;
      else if (flt_in[i] && det_en[i]) flags[i] <= 1'b1;
      else if (w1c[i])              flags[i] <= 1'b0;
    end
  end

  assign irq = |(flags & int_en);
endmodule

// File: rtl/xlat_csr_counter.sv
module xlat_csr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)             cnt <= '0;
    else if (inc && cnt != '1)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/xlat_csr_inval.sv
module xlat_csr_inval #(
  parameter int PN_W = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_cmd,
  input  logic            sd_cmd,
  input  logic [PN_W-1:0] sd_page_in,
  input  logic            clr_done,
  input  logic            sd_done,
  output logic            clr_busy,
  output logic            sd_busy,
  output logic [PN_W-1:0] sd_page
);
  logic idle;
  assign idle = !clr_busy && !sd_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_busy <= 1'b0;
      sd_busy  <= 1'b0;
      sd_page  <= '0;
    end else begin
      if (clr_busy && clr_done)  clr_busy <= 1'b0;
      else if (idle && clr_cmd)  clr_busy <= 1'b1;

      if (sd_busy && sd_done) begin
        sd_busy <= 1'b0;
      end else if (idle && sd_cmd && !clr_cmd) begin
        sd_busy <= 1'b1;
        sd_page <= {sd_page_in[PN_W-1:2], 2'b00};
      end
    end
  end
endmodule

// File: rtl/xlat_ctrl_csr.sv
module xlat_ctrl_csr
  import xlat_csr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32,
  parameter int PN_W   = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ev_hit,
  input  logic              ev_miss,
  input  logic              ev_stall,
  input  logic              flt_cap,
  input  logic              flt_pte,
  input  logic              flt_wrv,
  output logic              xlat_en,
  output logic              bypass_all,
  output logic              stats_en,
  output logic [2:0]        abort_en,
  output logic [2:0]        exc_en,
  output logic              irq,
  output logic              tlb_clr_req,
  input  logic              tlb_clr_done,
  output logic              sd_req,
  output logic [PN_W-1:0]   sd_page,
  input  logic              sd_done
);
  logic [31:0]     ctl_q;
  logic            ctl_wr, sd_wr, stat_clr;
  logic [NFLT-1:0] flags, w1c, det_en, int_en;
  logic            clr_busy, sd_busy;
  logic [CNT_W-1:0] cnt [NCNT];
  logic [NCNT-1:0]  ev_vec;

  assign ctl_wr = reg_we && (reg_addr == ADDR_W'(OFF_CTL));
  assign sd_wr  = reg_we && (reg_addr == ADDR_W'(OFF_SD));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      stat_clr <= 1'b0;
    end else begin
      stat_clr <= ctl_wr && reg_wdata[B_SCLR];
      if (ctl_wr) ctl_q <= reg_wdata & CTL_RW_MASK;
    end
  end

  for (genvar i = 0; i < NFLT; i++) begin : g_fdec
    assign w1c[i]      = ctl_wr && reg_wdata[FLAG_POS[i]];
    assign abort_en[i] = ctl_q[ABT_POS[i]];
    assign exc_en[i]   = ctl_q[EXC_POS[i]];
  end
  assign det_en = {1'b1, ctl_q[B_PTE_DET], 1'b1};
  assign int_en = {ctl_q[25], 1'b0, ctl_q[10]};

  assign xlat_en    = ctl_q[B_ENABLE];
  assign stats_en   = ctl_q[B_STATS];
  assign bypass_all = ctl_q[B_BYPASS];

  xlat_csr_fault u_fault (
    .clk, .rst,
    .flt_in ({flt_cap, flt_pte, flt_wrv}),
    .det_en, .w1c, .int_en,
    .flags, .irq
  );

  assign ev_vec = {ev_stall, ev_miss, ev_hit};
  for (genvar c = 0; c < NCNT; c++) begin : g_cnt
    xlat_csr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk, .rst,
      .clr (stat_clr),
      .inc (ev_vec[c] && stats_en),
      .cnt (cnt[c])
    );
  end

  xlat_csr_inval #(.PN_W(PN_W)) u_inval (
    .clk, .rst,
    .clr_cmd    (ctl_wr && reg_wdata[B_CLR]),
    .sd_cmd     (sd_wr && reg_wdata[B_SD_GO]),
    .sd_page_in (reg_wdata[PN_W-1:0]),
    .clr_done   (tlb_clr_done),
    .sd_done,
    .clr_busy, .sd_busy, .sd_page
  );
  assign tlb_clr_req = clr_busy;
  assign sd_req      = sd_busy;

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_W'(OFF_CTL): begin
        rd_mux = ctl_q;
        rd_mux[B_BUSY] = clr_busy;
        for (int i = 0; i < NFLT; i++) rd_mux[FLAG_POS[i]] = flags[i];
      end
      ADDR_W'(OFF_HIT):   rd_mux = 32'(cnt[0]);
      ADDR_W'(OFF_MISS):  rd_mux = 32'(cnt[1]);
      ADDR_W'(OFF_STALL): rd_mux = 32'(cnt[2]);
      ADDR_W'(OFF_SD): begin
        rd_mux = 32'(sd_page);
        rd_mux[B_SD_BUSY] = sd_busy;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/xlat_csr_chk.sv
module xlat_csr_chk #(
  parameter int CNT_W = 32,
  parameter int PN_W  = 24
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       flags,
  input logic [2:0]       w1c,
  input logic             clr_busy,
  input logic             sd_busy,
  input logic             tlb_clr_req,
  input logic             tlb_clr_done,
  input logic             sd_req,
  input logic             sd_done,
  input logic [PN_W-1:0]  sd_page,
  input logic             stats_en,
  input logic             stat_clr,
  input logic [CNT_W-1:0] cnt_hit
);
  // R4: a flag not being cleared never drops
  a_r4_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & $past(flags & ~w1c)) == $past(flags & ~w1c)));

  // R11: the two invalidations never run together
  a_r11_one_busy: assert property (@(posedge clk) disable iff (rst)
    !(clr_busy && sd_busy));

  // R9: clear request is held until done
  a_r9_clr_hold: assert property (@(posedge clk) disable iff (rst)
    tlb_clr_req && !tlb_clr_done |=> tlb_clr_req);

  // R10: shoot-down page is line aligned and steady during the request
  a_r10_sd_align: assert property (@(posedge clk) disable iff (rst)
    sd_req |-> (sd_page[1:0] == 2'b00));
  a_r10_sd_stable: assert property (@(posedge clk) disable iff (rst)
    sd_req && !sd_done |=> $stable(sd_page));

  // R6: counter frozen while statistics are off
  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    !stats_en && !stat_clr |=> $stable(cnt_hit));

  // R8: no wrap past all-ones
  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt_hit == '1) && !stat_clr |=> (cnt_hit == '1));
endmodule

bind xlat_ctrl_csr xlat_csr_chk #(.CNT_W(CNT_W), .PN_W(PN_W)) u_chk (
  .clk, .rst, .flags, .w1c, .clr_busy, .sd_busy,
  .tlb_clr_req, .tlb_clr_done, .sd_req, .sd_done, .sd_page,
  .stats_en, .stat_clr, .cnt_hit (cnt[0])
);

// File: tb/tb_xlat_ctrl_csr.sv
module tb_xlat_ctrl_csr;
  localparam int ADDR_W = 6;
  localparam int CNT_W  = 4;
  localparam int PN_W   = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ev_hit = 0, ev_miss = 0, ev_stall = 0;
  logic flt_cap = 0, flt_pte = 0, flt_wrv = 0;
  logic xlat_en, bypass_all, stats_en, irq, tlb_clr_req, sd_req;
  logic [2:0] abort_en, exc_en;
  logic tlb_clr_done = 0, sd_done = 0;
  logic [PN_W-1:0] sd_page;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  xlat_ctrl_csr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PN_W(PN_W)) dut (
    .clk, .rst, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .ev_hit, .ev_miss, .ev_stall, .flt_cap, .flt_pte, .flt_wrv,
    .xlat_en, .bypass_all, .stats_en, .abort_en, .exc_en, .irq,
    .tlb_clr_req, .tlb_clr_done, .sd_req, .sd_page, .sd_done
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = ADDR_W'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd('h00, v); chk("R1 ctl", v, 0);
    rd('h08, v); chk("R1 hit", v, 0);
    rd('h18, v); chk("R1 sd", v, 0);
    chk("R1 outs", {irq, xlat_en, bypass_all, stats_en, tlb_clr_req, sd_req}, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr('h00, 32'h070E_0F03);
    rd('h00, v); chk("R2 rw bits", v, 32'h070E_0F03);
    chk("R2 decode", {xlat_en, bypass_all, stats_en, abort_en, exc_en}, 9'h1FF);
    wr('h00, 32'h0000_0109);
    rd('h00, v); chk("R2 cmd bits read 0", v, 32'h0000_0101);
    chk("R2 decode2", {xlat_en, bypass_all, stats_en, abort_en, exc_en}, 9'h180);
    wr('h00, 0);
  endtask

  task automatic t_faults();
    logic [31:0] v;
    @(negedge clk); flt_cap = 1; flt_pte = 1; flt_wrv = 1;
    @(negedge clk); flt_cap = 0; flt_pte = 0; flt_wrv = 0;
    rd('h00, v); chk("R3 pte gated", v, 32'h0800_1000);
    wr('h00, 32'h0002_0000);
    @(negedge clk); flt_pte = 1;
    @(negedge clk); flt_pte = 0;
    rd('h00, v); chk("R3 all flags", v, 32'h0812_1000);
    wr('h00, 32'h0002_1000);
    rd('h00, v); chk("R4 w1c", v, 32'h0812_0000);
    @(negedge clk);
    reg_we = 1; reg_addr = 'h00; reg_wdata = 32'h0802_0000; flt_cap = 1;
    @(negedge clk); reg_we = 0; flt_cap = 0;
    rd('h00, v); chk("R4 set wins", v, 32'h0812_0000);
    chk("R5 no int en", irq, 0);
    wr('h00, 32'h0202_0000);
    chk("R5 cap irq", irq, 1);
    wr('h00, 32'h0a02_0000);
    chk("R5 pte no irq", irq, 0);
    wr('h00, 32'h0202_0400);
    @(negedge clk); flt_wrv = 1;
    @(negedge clk); flt_wrv = 0;
    chk("R5 wrv irq", irq, 1);
    wr('h00, 32'h0810_1000);
    rd('h00, v); chk("R4 all cleared", v, 0);
    chk("R5 irq low", irq, 0);
  endtask

  task automatic t_stats();
    logic [31:0] v;
    @(negedge clk); ev_hit = 1;
    repeat (3) @(negedge clk);
    ev_hit = 0;
    rd('h08, v); chk("R6 off no count", v, 0);
    wr('h00, 32'h2);
    @(negedge clk); ev_hit = 1; ev_miss = 1; ev_stall = 1;
    @(negedge clk); @(negedge clk); ev_miss = 0;
    @(negedge clk); ev_hit = 0;
    @(negedge clk); @(negedge clk); ev_stall = 0;
    rd('h08, v); chk("R6 hit", v, 3);
    rd('h0C, v); chk("R6 miss", v, 2);
    rd('h10, v); chk("R6 stall", v, 5);
    wr('h00, 32'hA);
    @(negedge clk);
    rd('h08, v); chk("R7 hit zero", v, 0);
    rd('h10, v); chk("R7 stall zero", v, 0);
    @(negedge clk); ev_hit = 1;
    repeat (20) @(negedge clk);
    ev_hit = 0;
    rd('h08, v); chk("R8 saturate", v, 15);
    wr('h00, 0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr('h00, 32'h4);
    chk("R9 req", tlb_clr_req, 1);
    rd('h00, v); chk("R9 busy bit", v, 32'h80);
    repeat (4) @(negedge clk);
    chk("R9 held", tlb_clr_req, 1);
    wr('h18, 32'h4000_0040);
    chk("R11 sd refused", sd_req, 0);
    rd('h18, v); chk("R11 page kept", v, 0);
    @(negedge clk); tlb_clr_done = 1;
    @(negedge clk); tlb_clr_done = 0;
    chk("R9 req drop", tlb_clr_req, 0);
    rd('h00, v); chk("R9 busy clear", v, 0);
  endtask

  task automatic t_sd();
    logic [31:0] v;
    wr('h18, 32'h4000_0123);
    chk("R10 req", sd_req, 1);
    chk("R10 page", 32'(sd_page), 32'h120);
    rd('h18, v); chk("R10 readback", v, 32'h8000_0120);
    wr('h18, 32'h4000_0400);
    rd('h18, v); chk("R11 sd ignored", v, 32'h8000_0120);
    wr('h00, 32'h4);
    chk("R11 clr refused", tlb_clr_req, 0);
    @(negedge clk); sd_done = 1;
    @(negedge clk); sd_done = 0;
    chk("R10 req drop", sd_req, 0);
    rd('h18, v); chk("R10 idle read", v, 32'h0000_0120);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl();
    t_faults();
    t_stats();
    t_clear();
    t_sd();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule